// File: doc/BRIEF.md
# Primary-Side Bridge Status Register

This block keeps the 32-bit status word that a PCI-X bridge shows for its primary interface. Four sticky flags record split-transaction trouble: a delayed split request, a completion overrun, an unexpected completion and a discarded completion. Software may read the flags, write them, and clear them. The other fields describe the bridge itself:

- a bit that always reports 133 MHz operation;
- a bus-width bit sampled from the 64-bit request strap while reset is held;
- a copy of the primary bus number;
- a device number that the block learns from configuration traffic;
- a fixed function number.

The device number is learned by watching decoded address phases. Any type 0 configuration write that selects this bridge loads AD[15:11] into the device field, whichever register the write targets. The bus, device and function fields together form the bridge's completer ID. The block compares that ID against the requester ID of each incoming split completion. A match with no outstanding request behind it raises the unexpected-completion flag.

Top module: `pcix_bridge_status`

## Requirements
- R1: During and just after a synchronous reset (`rst_n` low at a clock edge), `reg_rdata` has bits 21:18 at 0, bits 15:8 at 8'hFF and bits 7:3 at 5'b11111.
- R2: A one-cycle pulse on `evt_req_delayed`, `evt_cpl_overrun` or `evt_cpl_discard` sets bit 21, bit 20 or bit 18 respectively, starting in the cycle after the pulse.
- R3: The flags in bits 21:18 hold their value until software writes them. A cycle with `reg_wr` high loads them from `reg_wdata[21:18]`, so writing 0 clears a flag. If an event sets a flag in the same cycle as such a write, the flag ends up at 1.
- R4: Bit 17 always reads 1.
- R5: Bit 16 equals the inverse of `req64_n` as sampled at the last clock edge with `rst_n` low. It does not change while out of reset.
- R6: Bits 15:8 return the value `hdr_bus_num` had at the previous clock edge.
- R7: The device field, bits 7:3, loads `ap_ad[15:11]` at the clock edge of an `ap_valid` strobe only when all of these hold: `ap_cmd` is 4'b1011 (configuration write), `ap_idsel` is 1, `ap_ad[1:0]` is 2'b00, and `ap_ad[10:8]` equals `FUNC_NUM`. Otherwise the device field keeps its value.
- R8: Bits 2:0 read `FUNC_NUM`, and bits 31:22 read 0. Writes leave every bit outside 21:18 unchanged.
- R9: `completer_id` is {bus, device, function} as currently read. `cpl_id_match` is high when `cpl_valid` is high and `cpl_req_id` equals `completer_id`. If it is high while `cpl_outstanding` is low, bit 19 is set from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req64_n | input | 1 | Active-low 64-bit request strap |
| hdr_bus_num | input | 8 | Primary bus number from the type 1 header |
| ap_valid | input | 1 | One-cycle address-phase strobe |
| ap_cmd | input | 4 | Bus command of the address phase |
| ap_idsel | input | 1 | IDSEL during the address phase |
| ap_ad | input | 32 | AD bus during the address phase |
| evt_req_delayed | input | 1 | Split request held back by the commitment limit |
| evt_cpl_overrun | input | 1 | Split completion retried or disconnected, buffers full |
| evt_cpl_discard | input | 1 | Split completion discarded, requester refused it |
| cpl_valid | input | 1 | A split completion's requester ID is presented |
| cpl_req_id | input | 16 | Requester ID {bus, device, function} of that completion |
| cpl_outstanding | input | 1 | A matching request is outstanding |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Current register value |
| completer_id | output | 16 | Bridge ID {bus, device, function} |
| cpl_id_match | output | 1 | Completion requester ID equals bridge ID |

## Verification
Two pairs of functions can fall in the same cycle:

- An event pulse and a software write can hit the same flag together. The bench drives a write of all zeros in the cycle of a pulse and expects the pulsed flag to read 1 afterwards while the other flags clear.
- A device-number capture and an unexpected-completion comparison can coincide. The bench presents a qualifying configuration write and a completion whose ID carries the old device number in the same cycle. The comparison must use the old value, so bit 19 sets while the device field moves to the new number.

A behavioural model, compared on every clock, judges both cases.

// File: rtl/pcix_bridge_status.sv
module pcix_bridge_status #(
  parameter logic [2:0] FUNC_NUM = 3'd0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req64_n,
  input  logic [7:0]  hdr_bus_num,
  input  logic        ap_valid,
  input  logic [3:0]  ap_cmd,
  input  logic        ap_idsel,
  input  logic [31:0] ap_ad,
  input  logic        evt_req_delayed,
  input  logic        evt_cpl_overrun,
  input  logic        evt_cpl_discard,
  input  logic        cpl_valid,
  input  logic [15:0] cpl_req_id,
  input  logic        cpl_outstanding,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic [15:0] completer_id,
  output logic        cpl_id_match
);
  localparam logic [3:0] CMD_CFG_WR = 4'b1011;

  logic [3:0] flags;
  logic       wide_q;
  logic [7:0] bus_q;
  logic [4:0] dev_q;
  logic [3:0] set_vec;
  logic       dev_hit;

  wire unused_bits = ^{reg_wdata[31:22], reg_wdata[17:0], ap_ad[31:16], ap_ad[7:2]};

  assign completer_id = {bus_q, dev_q, FUNC_NUM};
  assign cpl_id_match = cpl_valid && (cpl_req_id == completer_id);
  assign set_vec      = {evt_req_delayed, evt_cpl_overrun,
                         cpl_id_match && !cpl_outstanding, evt_cpl_discard};
  assign dev_hit      = ap_valid && ap_cmd == CMD_CFG_WR && ap_idsel &&
                        ap_ad[1:0] == 2'b00 && ap_ad[10:8] == FUNC_NUM;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags <= '0;
      bus_q <= 8'hFF;
      dev_q <= 5'h1F;
    end else begin
      flags <= (reg_wr ? reg_wdata[21:18] : flags) | set_vec;
      bus_q <= hdr_bus_num;
      if (dev_hit) dev_q <= ap_ad[15:11];
    end
  end

  always_ff @(posedge clk)
    if (!rst_n) wide_q <= ~req64_n;

  assign reg_rdata = {10'd0, flags, 1'b1, wide_q, completer_id};
endmodule

module pcix_bridge_status_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  hdr_bus_num,
  input logic        ap_valid,
  input logic        evt_req_delayed,
  input logic        evt_cpl_overrun,
  input logic        cpl_outstanding,
  input logic        cpl_id_match,
  input logic        reg_wr,
  input logic [31:0] reg_rdata
);
  a_r2_delay_sets: assert property (@(posedge clk) disable iff (!rst_n)
    evt_req_delayed |=> reg_rdata[21]);
  a_r3_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    evt_cpl_overrun |=> reg_rdata[20]);
  a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[21] && !reg_wr) |=> reg_rdata[21]);
  a_r5_width_held: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(reg_rdata[16]));
  a_r6_bus_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> reg_rdata[15:8] == $past(hdr_bus_num));
  a_r7_dev_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ap_valid |=> $stable(reg_rdata[7:3]));
  a_r9_unexpected: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_id_match && !cpl_outstanding) |=> reg_rdata[19]);
endmodule

bind pcix_bridge_status pcix_bridge_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hdr_bus_num(hdr_bus_num), .ap_valid(ap_valid),
  .evt_req_delayed(evt_req_delayed), .evt_cpl_overrun(evt_cpl_overrun),
  .cpl_outstanding(cpl_outstanding), .cpl_id_match(cpl_id_match),
  .reg_wr(reg_wr), .reg_rdata(reg_rdata)
);

// File: tb/test_pcix_bridge_status.sv
module test_pcix_bridge_status;
  localparam logic [2:0] FN = 3'd0;
  logic clk = 0;
  always #2.5 clk = ~clk;

  logic        rst_n = 0, req64_n = 0, ap_valid = 0, ap_idsel = 0;
  logic [7:0]  hdr_bus_num = 8'h3C;
  logic [3:0]  ap_cmd = 0;
  logic [31:0] ap_ad = 0, reg_wdata = 0;
  logic        evt_req_delayed = 0, evt_cpl_overrun = 0, evt_cpl_discard = 0;
  logic        cpl_valid = 0, cpl_outstanding = 0, reg_wr = 0;
  logic [15:0] cpl_req_id = 0;
  logic [31:0] reg_rdata;
  logic [15:0] completer_id;
  logic        cpl_id_match;

  pcix_bridge_status #(.FUNC_NUM(FN)) i_pcix_bridge_status (.*);

  int checks = 0, failures = 0;
  bit done = 0;
  logic [3:0] m_flags;
  logic m_wide;
  logic [7:0] m_bus;
  logic [4:0] m_dev;
  bit m_valid = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_flags = 0; m_wide = !req64_n; m_bus = 8'hFF; m_dev = 5'h1F; m_valid = 1;
    end else if (m_valid) begin
      automatic bit hit = cpl_valid && !cpl_outstanding && cpl_req_id == {m_bus, m_dev, FN};
      automatic logic [3:0] nf = reg_wr ? reg_wdata[21:18] : m_flags;
      if (evt_req_delayed) nf[3] = 1;
      if (evt_cpl_overrun) nf[2] = 1;
      if (hit)             nf[1] = 1;
      if (evt_cpl_discard) nf[0] = 1;
      if (ap_valid && ap_cmd == 4'b1011 && ap_idsel && ap_ad[1:0] == 0 && ap_ad[10:8] == FN)
        m_dev = ap_ad[15:11];
      m_bus = hdr_bus_num;
      m_flags = nf;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (m_valid && !done) begin
    chk(rst_n ? "R2/R3 flags" : "R1 flags", 32'(reg_rdata[21:18]), 32'(m_flags));
    chk("R4 bit17", 32'(reg_rdata[17]), 32'd1);
    chk("R5 width", 32'(reg_rdata[16]), 32'(m_wide));
    chk(rst_n ? "R6 bus" : "R1 bus", 32'(reg_rdata[15:8]), 32'(m_bus));
    chk(rst_n ? "R7 dev" : "R1 dev", 32'(reg_rdata[7:3]), 32'(m_dev));
    chk("R8 func/upper", {reg_rdata[31:22], reg_rdata[2:0]}, 32'(FN));
    chk("R9 completer_id", 32'(completer_id), 32'({m_bus, m_dev, FN}));
    chk("R9 match", 32'(cpl_id_match),
        32'(cpl_valid && cpl_req_id == {m_bus, m_dev, FN}));
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic idle();
    ap_valid = 0; ap_cmd = 0; ap_idsel = 0; ap_ad = 0; reg_wr = 0; reg_wdata = 0;
    evt_req_delayed = 0; evt_cpl_overrun = 0; evt_cpl_discard = 0;
    cpl_valid = 0; cpl_outstanding = 0; cpl_req_id = 0;
  endtask

  task automatic cfg(logic [3:0] cmd, logic sel, logic [4:0] dev, logic [2:0] fn, logic [1:0] typ);
    ap_valid = 1; ap_cmd = cmd; ap_idsel = sel;
    ap_ad = {16'h5A00, dev, fn, 6'h2A, typ};
  endtask

  initial begin
    step(3);
    rst_n = 1; req64_n = 1;
    step(2);
    // R2: single pulses
    evt_req_delayed = 1; step(); idle(); step();
    evt_cpl_overrun = 1; step(); idle(); step();
    evt_cpl_discard = 1; step(); idle(); step();
    // R3: write zero while an event fires, then write ones incl. RO bits (R8)
    reg_wr = 1; reg_wdata = 0; evt_cpl_overrun = 1; step(); idle(); step(2);
    reg_wr = 1; reg_wdata = 32'hFFFF_FFFF; step(); idle(); step();
    reg_wr = 1; reg_wdata = 32'h0; step(); idle(); step();
    // R6: bus number follows header
    hdr_bus_num = 8'h12; step(2);
    // R7: non-qualifying phases
    cfg(4'b1010, 1, 5'h05, FN, 2'b00); step();
    cfg(4'b1011, 0, 5'h05, FN, 2'b00); step();
    cfg(4'b1011, 1, 5'h05, FN, 2'b01); step();
    cfg(4'b1011, 1, 5'h05, 3'd1, 2'b00); step();
    cfg(4'b1011, 1, 5'h05, FN, 2'b00); ap_valid = 0; step();
    idle(); step();
    // R7: qualifying phase
    cfg(4'b1011, 1, 5'h0A, FN, 2'b00); step(); idle(); step();
    // R9: matching ID with outstanding request -> no flag
    cpl_valid = 1; cpl_req_id = {8'h12, 5'h0A, FN}; cpl_outstanding = 1; step();
    cpl_outstanding = 0; cpl_req_id = {8'h13, 5'h0A, FN}; step();
    cpl_req_id = {8'h12, 5'h0A, FN}; step(); idle(); step();
    reg_wr = 1; step(); idle(); step();
    // capture and compare in the same cycle
    cfg(4'b1011, 1, 5'h11, FN, 2'b00);
    cpl_valid = 1; cpl_req_id = {8'h12, 5'h0A, FN}; step(); idle(); step(2);
    // R5: second reset with strap high
    rst_n = 0; req64_n = 1; step(2); req64_n = 0;
    rst_n = 1; step(3);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1; checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule